// File: doc/BRIEF.md
# Video Sync Source Selector

This block picks the horizontal sync, vertical sync and data-enable signals used inside a display pipeline from a set of candidate timing inputs. Two byte-wide control registers on a small address/data bus set the default source of each net. A separate force bit per net hands that net to a timing-controller pin instead, whatever the default says.

Every selected signal is brought into the clock domain through a two-flop synchroniser. The synchronised hsync and vsync leave the block through independently invertible outputs. Two reference strobes, one horizontal and one vertical, each give a one-clock pulse on the chosen edge (rising or falling) of a chosen synchronised source. Software changes any selection with a single register write.

Top module: `sync_src_sel`

## Requirements
- R1: After reset both control registers read 0x00 and every internal net, sync output and reference strobe is low.
- R2: A write occurs on a rising clock edge while `bus_we` is high. It loads register A at 0x0200 or register B at 0x0201. Bits [7:6] of register B read as zero and ignore writes. Any other address reads 0x00, and a write to it changes nothing.
- R3: Register A bits [1:0] pick the hsync source: 0 DVI, 1 LLK, 2 YUV, 3 raw VGA.
- R4: Register A bits [3:2] pick the vsync source: 0 DVI, 1 SRT, 2 YUV, 3 composite-sync decoder.
- R5: Register A bit 4 picks the enable source: 0 DVI, 1 YUV.
- R6: When set, register A bit 7 forces the timing-controller hsync pin onto the hsync net, bit 6 forces its vsync pin onto the vsync net and bit 5 forces its enable pin onto the enable net. Each force bit overrides the matching field of R3, R4 or R5.
- R7: A change on a selected input shows on the internal net after the second rising clock edge, and not after the first.
- R8: Register B bit 4 inverts `hs_out` relative to the internal hsync, and bit 5 inverts `vs_out` relative to the internal vsync.
- R9: `href_pulse` is high for one cycle on an edge of the internal enable (B bit 0 = 0) or the internal hsync (B bit 0 = 1). B bit 1 picks the edge: 1 for rising, 0 for falling. It is high in the cycle after the edge reaches the internal net.
- R10: `vref_pulse` is high for one cycle on an edge of the synchronised `vgen_en` (B bit 2 = 0) or the internal vsync (B bit 2 = 1). B bit 3 picks the edge: 1 for rising, 0 for falling. Its timing matches R9.
- R11: Rewriting a reference source or edge select takes effect at the next clock. Any pulse the rewrite produces lasts at most one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| dvi_hs | input | 1 | DVI hsync |
| dvi_vs | input | 1 | DVI vsync |
| dvi_de | input | 1 | DVI data enable |
| llk_hs | input | 1 | Line-locked (analog) hsync |
| yuv_hs | input | 1 | YUV interface hsync |
| yuv_vs | input | 1 | YUV interface vsync |
| yuv_de | input | 1 | YUV interface enable |
| vga_hs | input | 1 | Raw VGA hsync |
| srt_vs | input | 1 | Analog-path vsync |
| csd_vs | input | 1 | Composite sync decoder vsync |
| tcon_hs | input | 1 | Timing-controller hsync force source |
| tcon_vs | input | 1 | Timing-controller vsync force source |
| tcon_de | input | 1 | Timing-controller enable force source |
| vgen_en | input | 1 | Generated vertical enable |
| hs_int | output | 1 | Internal hsync |
| vs_int | output | 1 | Internal vsync |
| de_int | output | 1 | Internal enable |
| hs_out | output | 1 | Hsync output, optional inversion |
| vs_out | output | 1 | Vsync output, optional inversion |
| href_pulse | output | 1 | Horizontal reference strobe |
| vref_pulse | output | 1 | Vertical reference strobe |

## Verification
The three internal nets change two rising edges after an input change. The sync outputs follow them with no extra delay. A reference strobe is high during the cycle after that second edge, so the bench looks for it at the second falling edge after it drives a change. A register write changes the readback and the output inversion at the edge that performs the write. The bench therefore drives every input just after a falling edge and samples one nanosecond after a later falling edge. Routing vectors are allowed three cycles to settle. Strobe tests count pulses over a fixed six-cycle window and record the cycle in which the first pulse appears.

// File: rtl/sync_src_sel.sv
module sync_src_sel #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] A_ADDR  = 16'h0200,
  parameter logic [15:0] B_ADDR  = 16'h0201,
  parameter logic [7:0]  B_MASK  = 8'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dvi_hs,
  input  logic              dvi_vs,
  input  logic              dvi_de,
  input  logic              llk_hs,
  input  logic              yuv_hs,
  input  logic              yuv_vs,
  input  logic              yuv_de,
  input  logic              vga_hs,
  input  logic              srt_vs,
  input  logic              csd_vs,
  input  logic              tcon_hs,
  input  logic              tcon_vs,
  input  logic              tcon_de,
  input  logic              vgen_en,
  output logic              hs_int,
  output logic              vs_int,
  output logic              de_int,
  output logic              hs_out,
  output logic              vs_out,
  output logic              href_pulse,
  output logic              vref_pulse
);

  logic [7:0] reg_a, reg_b;
  logic       wr_a, wr_b;
  logic       hs_mux, vs_mux, de_mux;
  logic [3:0] sy1, sy2;
  logic       h_cur, v_cur, h_prev, v_prev;

  assign wr_a = bus_we && (bus_addr == A_ADDR[ADDR_W-1:0]);
  assign wr_b = bus_we && (bus_addr == B_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (wr_a) reg_a <= bus_wdata;
      if (wr_b) reg_b <= bus_wdata & B_MASK;
    end
  end

  always_comb begin
    if (bus_addr == A_ADDR[ADDR_W-1:0])      bus_rdata = reg_a;
    else if (bus_addr == B_ADDR[ADDR_W-1:0]) bus_rdata = reg_b;
    else                                     bus_rdata = '0;
  end

  always_comb begin
    case (reg_a[1:0])
      2'd0:    hs_mux = dvi_hs;
      2'd1:    hs_mux = llk_hs;
      2'd2:    hs_mux = yuv_hs;
      default: hs_mux = vga_hs;
    endcase
    if (reg_a[7]) hs_mux = tcon_hs;
    case (reg_a[3:2])
      2'd0:    vs_mux = dvi_vs;
      2'd1:    vs_mux = srt_vs;
      2'd2:    vs_mux = yuv_vs;
      default: vs_mux = csd_vs;
    endcase
    if (reg_a[6]) vs_mux = tcon_vs;
    de_mux = reg_a[5] ? tcon_de : (reg_a[4] ? yuv_de : dvi_de);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1    <= '0;
      sy2    <= '0;
      h_prev <= 1'b0;
      v_prev <= 1'b0;
    end else begin
      sy1    <= {hs_mux, vs_mux, de_mux, vgen_en};
      sy2    <= sy1;
      h_prev <= h_cur;
      v_prev <= v_cur;
    end
  end

  assign hs_int = sy2[3];
  assign vs_int = sy2[2];
  assign de_int = sy2[1];
  assign hs_out = hs_int ^ reg_b[4];
  assign vs_out = vs_int ^ reg_b[5];

  assign h_cur = reg_b[0] ? hs_int : de_int;
  assign v_cur = reg_b[2] ? vs_int : sy2[0];
  assign href_pulse = reg_b[1] ? (h_cur & ~h_prev) : (~h_cur & h_prev);
  assign vref_pulse = reg_b[3] ? (v_cur & ~v_prev) : (~v_cur & v_prev);

  p_force_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_a[7], 2) |-> hs_int == $past(tcon_hs, 2));
  p_force_vs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_a[6], 2) |-> vs_int == $past(tcon_vs, 2));
  p_force_de_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_a[5], 2) |-> de_int == $past(tcon_de, 2));
  p_href_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    href_pulse |=> (!href_pulse || $past(wr_b)));
  p_vref_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vref_pulse |=> (!vref_pulse || $past(wr_b)));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |=> reg_b[7:6] == 2'b00);

endmodule

// File: tb/sync_src_sel_tb.sv
module sync_src_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [12:0] stim = '0;
  logic        vgen = 1'b0;
  logic        hs_int, vs_int, de_int, hs_out, vs_out, href_pulse, vref_pulse;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sync_src_sel dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dvi_hs(stim[12]), .dvi_vs(stim[11]), .dvi_de(stim[10]), .llk_hs(stim[9]),
    .yuv_hs(stim[8]), .yuv_vs(stim[7]), .yuv_de(stim[6]), .vga_hs(stim[5]),
    .srt_vs(stim[4]), .csd_vs(stim[3]), .tcon_hs(stim[2]), .tcon_vs(stim[1]),
    .tcon_de(stim[0]), .vgen_en(vgen),
    .hs_int(hs_int), .vs_int(vs_int), .de_int(de_int), .hs_out(hs_out),
    .vs_out(vs_out), .href_pulse(href_pulse), .vref_pulse(vref_pulse));

  // {reg A, reg B, stim, expected {hs_int, vs_int, de_int, hs_out, vs_out}}
  localparam logic [33:0] VEC [19] = '{
    {8'h00, 8'h00, 13'h1000, 5'b10010},  // R3 dvi hs
    {8'h00, 8'h00, 13'h1C00, 5'b11111},  // R3 R4 R5 dvi all
    {8'h00, 8'h00, 13'h03FF, 5'b00000},  // R3 others ignored
    {8'h01, 8'h00, 13'h0200, 5'b10010},  // R3 llk
    {8'h02, 8'h00, 13'h0100, 5'b10010},  // R3 yuv
    {8'h03, 8'h00, 13'h0020, 5'b10010},  // R3 vga
    {8'h03, 8'h00, 13'h0200, 5'b00000},  // R3 llk not picked
    {8'h04, 8'h00, 13'h0010, 5'b01001},  // R4 srt
    {8'h08, 8'h00, 13'h0080, 5'b01001},  // R4 yuv
    {8'h0C, 8'h00, 13'h0008, 5'b01001},  // R4 csd
    {8'h10, 8'h00, 13'h0040, 5'b00100},  // R5 yuv
    {8'h10, 8'h00, 13'h0400, 5'b00000},  // R5 dvi not picked
    {8'h80, 8'h00, 13'h1000, 5'b00000},  // R6 hs force beats field
    {8'h80, 8'h00, 13'h0004, 5'b10010},  // R6 hs force
    {8'h40, 8'h00, 13'h0002, 5'b01001},  // R6 vs force
    {8'h20, 8'h00, 13'h0001, 5'b00100},  // R6 de force
    {8'hE3, 8'h00, 13'h0007, 5'b11111},  // R6 all forced
    {8'h00, 8'h30, 13'h0000, 5'b00011},  // R8 both inverted
    {8'h00, 8'h10, 13'h1800, 5'b11001}   // R8 hs inverted only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_addr = '0;
  endtask

  task automatic ref_case(input string req, input logic [7:0] b, input bit vert,
                          input logic [12:0] s0, input bit g0,
                          input logic [12:0] s1, input bit g1,
                          input int exp_n, input int exp_at);
    int n, at;
    wr(16'h0200, 8'h00); wr(16'h0201, b);
    stim = s0; vgen = g0;
    repeat (4) @(negedge clk);
    #1; stim = s1; vgen = g1;
    n = 0; at = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk); #1;
      if (vert ? vref_pulse : href_pulse) begin
        n++;
        if (at == 0) at = k;
      end
    end
    chk({req, " count"}, n, exp_n);
    if (exp_n > 0) chk({req, " cycle"}, at, exp_at);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reg A", dut_i.bus_rdata, 8'h00);
    chk("R1 outputs", {hs_int, vs_int, de_int, hs_out, vs_out, href_pulse, vref_pulse}, 7'h0);
    rst_n = 1'b1;
    rd("R1 reg A read", 16'h0200, 8'h00);
    rd("R1 reg B read", 16'h0201, 8'h00);

    wr(16'h0200, 8'hA5);
    rd("R2 reg A readback", 16'h0200, 8'hA5);
    wr(16'h0201, 8'hFF);
    rd("R2 reserved bits zero", 16'h0201, 8'h3F);
    wr(16'h0202, 8'hAA);
    rd("R2 unmapped read", 16'h0202, 8'h00);
    rd("R2 unmapped write no effect A", 16'h0200, 8'hA5);
    rd("R2 unmapped write no effect B", 16'h0201, 8'h3F);

    foreach (VEC[i]) begin
      wr(16'h0200, VEC[i][33:26]);
      wr(16'h0201, VEC[i][25:18]);
      stim = VEC[i][17:5];
      repeat (3) @(negedge clk);
      #1;
      chk($sformatf("R3-8 vector %0d", i), {hs_int, vs_int, de_int, hs_out, vs_out}, VEC[i][4:0]);
    end

    // R7 latency
    wr(16'h0200, 8'h00); wr(16'h0201, 8'h00);
    stim = '0;
    repeat (3) @(negedge clk);
    #1; stim = 13'h1000;
    @(negedge clk); #1;
    chk("R7 not after first edge", hs_int, 1'b0);
    @(negedge clk); #1;
    chk("R7 after second edge", hs_int, 1'b1);

    ref_case("R9 de rising",      8'h02, 1'b0, 13'h0000, 1'b0, 13'h0400, 1'b0, 1, 2);
    ref_case("R9 de rising skip fall", 8'h02, 1'b0, 13'h0400, 1'b0, 13'h0000, 1'b0, 0, 0);
    ref_case("R9 de falling",     8'h00, 1'b0, 13'h0400, 1'b0, 13'h0000, 1'b0, 1, 2);
    ref_case("R9 hs rising",      8'h03, 1'b0, 13'h0000, 1'b0, 13'h1000, 1'b0, 1, 2);
    ref_case("R9 hs src ignores de", 8'h03, 1'b0, 13'h0000, 1'b0, 13'h0400, 1'b0, 0, 0);
    ref_case("R10 vgen rising",   8'h08, 1'b1, 13'h0000, 1'b0, 13'h0000, 1'b1, 1, 2);
    ref_case("R10 vs falling",    8'h04, 1'b1, 13'h0800, 1'b0, 13'h0000, 1'b0, 1, 2);
    ref_case("R10 vs src ignores vgen", 8'h0C, 1'b1, 13'h0000, 1'b0, 13'h0000, 1'b1, 0, 0);

    // R11 source switch: de low, hs high, switch href source to hs (rising)
    begin
      int n, at;
      wr(16'h0200, 8'h00); wr(16'h0201, 8'h02);
      stim = 13'h1000;
      repeat (4) @(negedge clk);
      bus_addr = 16'h0201; bus_wdata = 8'h03; bus_we = 1'b1;
      n = 0; at = 0;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk); bus_we = 1'b0; bus_addr = '0; #1;
        if (href_pulse) begin
          n++;
          if (at == 0) at = k;
        end
      end
      chk("R11 switch pulse count", n, 1);
      chk("R11 switch immediate", at, 1);
    end

    finish_run();
  end
endmodule